// File: doc/BRIEF.md
# Calendar Time Counter with Alarm Compare

This block keeps wall-clock time and date: seconds, minutes, hours, day of week, day of month, month and a two-digit year. It advances once for every one-second tick it accepts. The time is shown in BCD or in plain binary, and the hour in 24-hour or 12-hour form with a PM marker. An alarm compare with per-field wildcards, an update-ended flag and an interrupt line let software follow the time without polling.

Each accepted tick starts a two-phase update. A small state machine handles it. In `ST_IDLE` an accepted tick advances the internal binary time, raises the update-in-progress flag (unless set mode is on) and moves to `ST_WAIT`. `ST_WAIT` counts down a window of `UIP_CYCLES` cycles and then moves to `ST_FINISH`. In `ST_FINISH` the visible registers are refreshed from the internal time (unless set mode is on), the alarm is compared, the flags are raised, and the machine returns to `ST_IDLE`. A load strobe writes a complete time and date, given in the current display format.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the second, minute, hour and year registers read 0x00. Day of week, day of month and month read 0x01. The flags `uip`, `alarm_flag`, `upd_flag` and `irq` are 0.
- R2: A tick is accepted only when `div_sel` equals 3'b010 and the state machine is in `ST_IDLE`. Any other tick has no effect on the registers or flags.
- R3: When a tick is sampled at a clock edge, `uip` is 1 from the next cycle for `UIP_CYCLES`+1 cycles, provided `set_mode`=0. In the cycle `uip` falls, the registers show the new time and `upd_flag` is 1. With `set_mode`=1, `uip` stays 0 and the registers are not refreshed, but the internal time still advances and `upd_flag` is still set.
- R4: Seconds and minutes wrap from 59 to 0 and carry. Hours wrap from 23 to 0 and carry into the date. Day of week runs 1 to 7 and then back to 1. Month lengths are 31/30/28. February has 29 days when the full year (`CENTURY`*100 + year) is divisible by 4 and either not by 100 or by 400. Month 12 wraps to 1, and year 99 wraps to 0.
- R5: With `bin_mode`=0 each register is BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0. With `bin_mode`=1 the register holds the plain binary value.
- R6: With `h24_mode`=0 the hour register shows 1 to 12. Bit 7 is set for hours 12 to 23, and internal hour 0 is shown as 12.
- R7: `load_stb` decodes the `ld_*` bytes in the current format into the internal time. In 12-hour mode the hour becomes (value mod 12), plus 12 when bit 7 is set. The registers show the loaded bytes on the next cycle. A tick in the same cycle as `load_stb` is dropped.
- R8: An alarm byte with bits 7:6 both 1 matches any value. Any other alarm byte is decoded like a load byte (hour as in R7) and compared with the internal time. `alarm_flag` is set in `ST_FINISH` when all three fields match.
- R9: `irq` is set together with `upd_flag` when `upd_irq_en`=1, and together with `alarm_flag` when `alm_irq_en`=1. Otherwise those flags are set without `irq`.
- R10: `flag_ack` clears `alarm_flag`, `upd_flag` and `irq`. If the ack falls in the same cycle as `ST_FINISH`, the newly raised flags survive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse per second |
| div_sel | input | 3 | Oscillator divider control; 3'b010 means run |
| bin_mode | input | 1 | 1 = binary values, 0 = BCD |
| h24_mode | input | 1 | 1 = 24-hour, 0 = 12-hour with PM bit |
| set_mode | input | 1 | Freeze the visible registers and suppress `uip` |
| upd_irq_en | input | 1 | Update-ended interrupt enable |
| alm_irq_en | input | 1 | Alarm interrupt enable |
| load_stb | input | 1 | Load the `ld_*` bytes |
| ld_sec | input | 8 | Seconds to load |
| ld_min | input | 8 | Minutes to load |
| ld_hour | input | 8 | Hour to load |
| ld_wday | input | 8 | Day of week to load |
| ld_mday | input | 8 | Day of month to load |
| ld_mon | input | 8 | Month to load |
| ld_year | input | 8 | Year to load |
| alm_sec | input | 8 | Alarm seconds |
| alm_min | input | 8 | Alarm minutes |
| alm_hour | input | 8 | Alarm hour |
| flag_ack | input | 1 | Clear the alarm, update and interrupt flags |
| r_sec | output | 8 | Seconds register |
| r_min | output | 8 | Minutes register |
| r_hour | output | 8 | Hour register |
| r_wday | output | 8 | Day-of-week register |
| r_mday | output | 8 | Day-of-month register |
| r_mon | output | 8 | Month register |
| r_year | output | 8 | Year register |
| uip | output | 1 | Update in progress |
| alarm_flag | output | 1 | Alarm matched |
| upd_flag | output | 1 | Update ended |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can meet in one cycle. A flag acknowledge can land in the exact cycle that `ST_FINISH` raises new flags. The bench provokes this by counting `UIP_CYCLES`+1 edges after the tick before it asserts `flag_ack`, and it judges the outcome by requiring `upd_flag` to remain set. A load strobe can also coincide with an accepted tick. Here the bench expects no update window to open and the loaded bytes to stay visible. A behavioural model compares every register and flag on every cycle, so both collisions are also checked against the model.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_FINISH} upd_state_e;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [6:0] hour;
        logic [6:0] wday;
        logic [6:0] mday;
        logic [6:0] mon;
        logic [6:0] year;
    } cal_t;

    function automatic logic [7:0] to_reg(input logic [6:0] v, input logic bin);
        logic [6:0] tens;
        logic [6:0] units;
        tens  = v / 7'd10;
        units = v % 7'd10;
        return bin ? {1'b0, v} : {tens[3:0], units[3:0]};
    endfunction

    function automatic logic [6:0] from_reg(input logic [7:0] r, input logic bin);
        logic [6:0] hi;
        hi = {3'b000, r[7:4]};
        return bin ? r[6:0] : (hi * 7'd10 + {3'b000, r[3:0]});
    endfunction

    function automatic logic [7:0] hour_to_reg(input logic [6:0] h, input logic bin,
                                               input logic h24);
        logic [6:0] h12;
        if (h24) return to_reg(h, bin);
        h12 = (h == 7'd0) ? 7'd12 : ((h > 7'd12) ? h - 7'd12 : h);
        return to_reg(h12, bin) | {(h >= 7'd12), 7'b0};
    endfunction

    function automatic logic [6:0] hour_from_reg(input logic [7:0] r, input logic bin,
                                                 input logic h24);
        logic [6:0] v;
        v = from_reg({1'b0, r[6:0]}, bin);
        if (h24) return v;
        return (v % 7'd12) + (r[7] ? 7'd12 : 7'd0);
    endfunction

    function automatic logic [6:0] days_in_month(input logic [6:0] mon, input logic [6:0] year,
                                                 input logic cent_leap);
        logic leap;
        leap = (year[1:0] == 2'b00) && ((year != 7'd0) || cent_leap);
        case (mon)
            7'd4, 7'd6, 7'd9, 7'd11: return 7'd30;
            7'd2:                    return leap ? 7'd29 : 7'd28;
            default:                 return 7'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_cal_tod.sv
module rtc_cal_tod
    import rtc_cal_pkg::*;
#(
    parameter int unsigned CENTURY = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic ld,
    input  cal_t ld_val,
    output cal_t now
);
    localparam logic CENT_LEAP = ((CENTURY % 4) == 0);

    cal_t nxt;

    always_comb begin
        nxt = now;
        if (now.sec >= 7'd59) begin
            nxt.sec = 7'd0;
            if (now.min >= 7'd59) begin
                nxt.min = 7'd0;
                if (now.hour >= 7'd23) begin
                    nxt.hour = 7'd0;
                    nxt.wday = (now.wday >= 7'd7) ? 7'd1 : now.wday + 7'd1;
                    if (now.mday >= days_in_month(now.mon, now.year, CENT_LEAP)) begin
                        nxt.mday = 7'd1;
                        if (now.mon >= 7'd12) begin
                            nxt.mon  = 7'd1;
                            nxt.year = (now.year >= 7'd99) ? 7'd0 : now.year + 7'd1;
                        end else begin
                            nxt.mon = now.mon + 7'd1;
                        end
                    end else begin
                        nxt.mday = now.mday + 7'd1;
                    end
                end else begin
                    nxt.hour = now.hour + 7'd1;
                end
            end else begin
                nxt.min = now.min + 7'd1;
            end
        end else begin
            nxt.sec = now.sec + 7'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now <= '{sec: 7'd0, min: 7'd0, hour: 7'd0, wday: 7'd1,
                     mday: 7'd1, mon: 7'd1, year: 7'd0};
        end else if (ld) begin
            now <= ld_val;
        end else if (adv) begin
            now <= nxt;
        end
    end

    // R4
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ld && now.sec == 7'd59) |=> (now.sec == 7'd0));

    // R4
    wday_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ld && now.wday == 7'd7 && now.hour == 7'd23 && now.min == 7'd59
         && now.sec == 7'd59) |=> (now.wday == 7'd1));

endmodule

// File: rtl/rtc_cal_fmt.sv
module rtc_cal_fmt
    import rtc_cal_pkg::*;
(
    input  cal_t             t,
    input  logic             bin,
    input  logic             h24,
    output logic [6:0][7:0]  regs
);
    always_comb begin
        regs[0] = to_reg(t.sec, bin);
        regs[1] = to_reg(t.min, bin);
        regs[2] = hour_to_reg(t.hour, bin, h24);
        regs[3] = to_reg(t.wday, bin);
        regs[4] = to_reg(t.mday, bin);
        regs[5] = to_reg(t.mon, bin);
        regs[6] = to_reg(t.year, bin);
    end
endmodule

// File: rtl/rtc_cal_alarm.sv
module rtc_cal_alarm
    import rtc_cal_pkg::*;
#(
    parameter int unsigned FIELDS = 3
) (
    input  cal_t        t,
    input  logic        bin,
    input  logic        h24,
    input  logic [7:0]  alm_sec,
    input  logic [7:0]  alm_min,
    input  logic [7:0]  alm_hour,
    output logic        hit
);
    localparam int unsigned HOUR_IDX = FIELDS - 1;

    logic [FIELDS-1:0][7:0] raw;
    logic [FIELDS-1:0][6:0] have;
    logic [FIELDS-1:0]      field_hit;

    assign raw  = {alm_hour, alm_min, alm_sec};
    assign have = {t.hour, t.min, t.sec};

    for (genvar g = 0; g < FIELDS; g++) begin : g_field
        logic [6:0] want;
        if (g == HOUR_IDX) begin : g_hour
            assign want = hour_from_reg(raw[g], bin, h24);
        end else begin : g_plain
            assign want = from_reg(raw[g], bin);
        end
        assign field_hit[g] = (raw[g][7:6] == 2'b11) || (want == have[g]);
    end

    assign hit = &field_hit;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int unsigned UIP_CYCLES = 4,
    parameter int unsigned CENTURY    = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic [2:0] div_sel,
    input  logic       bin_mode,
    input  logic       h24_mode,
    input  logic       set_mode,
    input  logic       upd_irq_en,
    input  logic       alm_irq_en,
    input  logic       load_stb,
    input  logic [7:0] ld_sec,
    input  logic [7:0] ld_min,
    input  logic [7:0] ld_hour,
    input  logic [7:0] ld_wday,
    input  logic [7:0] ld_mday,
    input  logic [7:0] ld_mon,
    input  logic [7:0] ld_year,
    input  logic [7:0] alm_sec,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_hour,
    input  logic       flag_ack,
    output logic [7:0] r_sec,
    output logic [7:0] r_min,
    output logic [7:0] r_hour,
    output logic [7:0] r_wday,
    output logic [7:0] r_mday,
    output logic [7:0] r_mon,
    output logic [7:0] r_year,
    output logic       uip,
    output logic       alarm_flag,
    output logic       upd_flag,
    output logic       irq
);
    localparam int unsigned     NREG    = 7;
    localparam int unsigned     HOUR_IX = 2;
    localparam int unsigned     CW      = $clog2(UIP_CYCLES + 1);
    localparam logic [2:0]      RUN_DIV = 3'b010;
    localparam logic [CW-1:0]   WIN_START = CW'(UIP_CYCLES - 1);

    upd_state_e          state;
    logic [CW-1:0]       cnt;
    logic                adv;
    logic                alm_hit;
    cal_t                now;
    cal_t                ld_val;
    logic [NREG-1:0][7:0] ld_raw;
    logic [NREG-1:0][6:0] ld_bin;
    logic [NREG-1:0][7:0] fmt_regs;
    logic [NREG-1:0][7:0] disp;
    logic                new_uf;
    logic                new_af;
    logic                new_irq;

    assign ld_raw = {ld_year, ld_mon, ld_mday, ld_wday, ld_hour, ld_min, ld_sec};

    for (genvar g = 0; g < NREG; g++) begin : g_ld
        if (g == HOUR_IX) begin : g_hour
            assign ld_bin[g] = hour_from_reg(ld_raw[g], bin_mode, h24_mode);
        end else begin : g_plain
            assign ld_bin[g] = from_reg(ld_raw[g], bin_mode);
        end
    end

    assign ld_val = '{sec: ld_bin[0], min: ld_bin[1], hour: ld_bin[2], wday: ld_bin[3],
                      mday: ld_bin[4], mon: ld_bin[5], year: ld_bin[6]};

    assign adv = (state == ST_IDLE) && sec_tick && (div_sel == RUN_DIV) && !load_stb;

    rtc_cal_tod #(.CENTURY(CENTURY)) u_tod (
        .clk(clk), .rst_n(rst_n), .adv(adv), .ld(load_stb), .ld_val(ld_val), .now(now)
    );

    rtc_cal_fmt u_fmt (
        .t(now), .bin(bin_mode), .h24(h24_mode), .regs(fmt_regs)
    );

    rtc_cal_alarm #(.FIELDS(3)) u_alarm (
        .t(now), .bin(bin_mode), .h24(h24_mode),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour), .hit(alm_hit)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (adv) begin
                        state <= ST_WAIT;
                        cnt   <= WIN_START;
                    end
                end
                ST_WAIT: begin
                    if (cnt == '0) state <= ST_FINISH;
                    else           cnt   <= cnt - 1'b1;
                end
                ST_FINISH: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    assign new_uf  = (state == ST_FINISH);
    assign new_af  = (state == ST_FINISH) && alm_hit;
    assign new_irq = (new_uf && upd_irq_en) || (new_af && alm_irq_en);

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp       <= {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
            uip        <= 1'b0;
            alarm_flag <= 1'b0;
            upd_flag   <= 1'b0;
            irq        <= 1'b0;
        end else begin
            if (load_stb)                             disp <= ld_raw;
            else if (state == ST_FINISH && !set_mode) disp <= fmt_regs;

            if (adv)                     uip <= !set_mode;
            else if (state == ST_FINISH) uip <= 1'b0;

            alarm_flag <= (alarm_flag && !flag_ack) || new_af;
            upd_flag   <= (upd_flag && !flag_ack) || new_uf;
            irq        <= (irq && !flag_ack) || new_irq;
        end
    end

    assign r_sec  = disp[0];
    assign r_min  = disp[1];
    assign r_hour = disp[2];
    assign r_wday = disp[3];
    assign r_mday = disp[4];
    assign r_mon  = disp[5];
    assign r_year = disp[6];

    // R2
    div_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && sec_tick && div_sel != RUN_DIV) |=> (state == ST_IDLE));

    // R3
    uip_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(uip) |-> ($past(state) == ST_FINISH));

    // R3
    set_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINISH && set_mode && !load_stb) |=> $stable(disp));

    // R8
    alarm_when_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> ($past(state) == ST_FINISH));

    // R9
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(upd_irq_en || alm_irq_en));

    // R10
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_ack && state != ST_FINISH) |=> (!irq && !upd_flag && !alarm_flag));

endmodule

// File: tb/rtc_calendar_bench.sv
module rtc_calendar_bench;
    localparam int UIPC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sec_tick = 1'b0;
    logic [2:0] div_sel = 3'b010;
    logic bin_mode = 1'b0, h24_mode = 1'b1, set_mode = 1'b0;
    logic upd_irq_en = 1'b0, alm_irq_en = 1'b0, load_stb = 1'b0, flag_ack = 1'b0;
    logic [7:0] ld_sec = 0, ld_min = 0, ld_hour = 0, ld_wday = 1, ld_mday = 1, ld_mon = 1, ld_year = 0;
    logic [7:0] alm_sec = 8'h00, alm_min = 8'h00, alm_hour = 8'h00;
    logic [7:0] r_sec, r_min, r_hour, r_wday, r_mday, r_mon, r_year;
    logic uip, alarm_flag, upd_flag, irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    rtc_calendar #(.UIP_CYCLES(UIPC), .CENTURY(20)) u_rtc_calendar (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .div_sel(div_sel),
        .bin_mode(bin_mode), .h24_mode(h24_mode), .set_mode(set_mode),
        .upd_irq_en(upd_irq_en), .alm_irq_en(alm_irq_en), .load_stb(load_stb),
        .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour), .ld_wday(ld_wday),
        .ld_mday(ld_mday), .ld_mon(ld_mon), .ld_year(ld_year),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour), .flag_ack(flag_ack),
        .r_sec(r_sec), .r_min(r_min), .r_hour(r_hour), .r_wday(r_wday),
        .r_mday(r_mday), .r_mon(r_mon), .r_year(r_year),
        .uip(uip), .alarm_flag(alarm_flag), .upd_flag(upd_flag), .irq(irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    function automatic int benc(int v, bit bin);
        return bin ? v : (((v / 10) << 4) | (v % 10));
    endfunction
    function automatic int bhenc(int h, bit bin, bit h24);
        int h12;
        if (h24) return benc(h, bin);
        h12 = (h % 12 == 0) ? 12 : h % 12;
        return benc(h12, bin) | ((h >= 12) ? 128 : 0);
    endfunction
    function automatic int bdec(int r, bit bin);
        return bin ? (r & 127) : (((r >> 4) & 15) * 10 + (r & 15));
    endfunction
    function automatic int bhdec(int r, bit bin, bit h24);
        int v;
        v = bdec(r & 127, bin);
        if (h24) return v;
        return (v % 12) + (((r & 128) != 0) ? 12 : 0);
    endfunction
    function automatic int bdim(int m, int y);
        int full;
        full = 2000 + y;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        if (m == 2) return ((full % 4 == 0) && ((full % 100 != 0) || (full % 400 == 0))) ? 29 : 28;
        return 31;
    endfunction

    int ms, mm, mh, mw, md, mo, my;
    int mdisp[7];
    int m_busy;
    bit m_uip, m_af, m_uf, m_irq;
    bit naf, nuf, was_idle;

    task automatic m_advance();
        ms++;
        if (ms >= 60) begin
            ms = 0; mm++;
            if (mm >= 60) begin
                mm = 0; mh++;
                if (mh >= 24) begin
                    mh = 0;
                    mw = (mw >= 7) ? 1 : mw + 1;
                    md++;
                    if (md > bdim(mo, my)) begin
                        md = 1; mo++;
                        if (mo > 12) begin mo = 1; my = (my + 1) % 100; end
                    end
                end
            end
        end
    endtask

    function automatic bit m_field(int raw, int dec, int have);
        return ((raw & 192) == 192) || (dec == have);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; mm = 0; mh = 0; mw = 1; md = 1; mo = 1; my = 0;
            mdisp = '{0, 0, 0, 1, 1, 1, 0};
            m_busy = 0; m_uip = 0; m_af = 0; m_uf = 0; m_irq = 0;
        end else begin
            naf = 0; nuf = 0;
            was_idle = (m_busy == 0);
            if (m_busy == 1) begin
                if (!set_mode) begin
                    mdisp[0] = benc(ms, bin_mode); mdisp[1] = benc(mm, bin_mode);
                    mdisp[2] = bhenc(mh, bin_mode, h24_mode); mdisp[3] = benc(mw, bin_mode);
                    mdisp[4] = benc(md, bin_mode); mdisp[5] = benc(mo, bin_mode);
                    mdisp[6] = benc(my, bin_mode);
                end
                naf = m_field(alm_sec, bdec(alm_sec, bin_mode), ms)
                   && m_field(alm_min, bdec(alm_min, bin_mode), mm)
                   && m_field(alm_hour, bhdec(alm_hour, bin_mode, h24_mode), mh);
                nuf = 1;
                m_uip = 0;
            end
            if (m_busy > 0) m_busy--;
            if (load_stb) begin
                ms = bdec(ld_sec, bin_mode); mm = bdec(ld_min, bin_mode);
                mh = bhdec(ld_hour, bin_mode, h24_mode); mw = bdec(ld_wday, bin_mode);
                md = bdec(ld_mday, bin_mode); mo = bdec(ld_mon, bin_mode);
                my = bdec(ld_year, bin_mode);
                mdisp = '{ld_sec, ld_min, ld_hour, ld_wday, ld_mday, ld_mon, ld_year};
            end else if (was_idle && sec_tick && div_sel == 3'b010) begin
                m_advance();
                m_busy = UIPC + 1;
                m_uip = !set_mode;
            end
            m_irq = (m_irq && !flag_ack) || (nuf && upd_irq_en) || (naf && alm_irq_en);
            m_af  = (m_af && !flag_ack) || naf;
            m_uf  = (m_uf && !flag_ack) || nuf;
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4", "r_sec",  r_sec,  mdisp[0]);
            chk("R4", "r_min",  r_min,  mdisp[1]);
            chk("R6", "r_hour", r_hour, mdisp[2]);
            chk("R4", "r_wday", r_wday, mdisp[3]);
            chk("R4", "r_mday", r_mday, mdisp[4]);
            chk("R4", "r_mon",  r_mon,  mdisp[5]);
            chk("R4", "r_year", r_year, mdisp[6]);
            chk("R3", "uip", uip, m_uip);
            chk("R8", "alarm_flag", alarm_flag, m_af);
            chk("R3", "upd_flag", upd_flag, m_uf);
            chk("R9", "irq", irq, m_irq);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic load(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                        input logic [7:0] w, input logic [7:0] d, input logic [7:0] mon,
                        input logic [7:0] y);
        @(negedge clk);
        ld_sec = s; ld_min = m; ld_hour = h; ld_wday = w; ld_mday = d; ld_mon = mon; ld_year = y;
        load_stb = 1'b1;
        @(negedge clk);
        load_stb = 1'b0;
    endtask

    task automatic do_tick(output int hi);
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        hi = 0;
        repeat (UIPC + 4) begin
            if (uip) hi++;
            @(negedge clk);
        end
    endtask

    task automatic ack();
        @(negedge clk); flag_ack = 1'b1;
        @(negedge clk); flag_ack = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R3 watchdog actual=timeout expected=finished");
        finish_run();
    end

    initial begin
        int hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "reset r_sec", r_sec, 8'h00);
        chk("R1", "reset r_wday", r_wday, 8'h01);
        chk("R1", "reset r_mon", r_mon, 8'h01);
        chk("R1", "reset flags", {uip, alarm_flag, upd_flag, irq}, 0);

        // R3 update window and R4/R5 rollover of everything, BCD 24h
        load(8'h58, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        do_tick(hi);
        chk("R3", "uip window", hi, UIPC + 1);
        chk("R5", "bcd sec 59", r_sec, 8'h59);
        chk("R3", "upd_flag set", upd_flag, 1);
        do_tick(hi);
        chk("R4", "new year sec/min/hour", {r_sec, r_min, r_hour}, 24'h000000);
        chk("R4", "wday wrap", r_wday, 8'h01);
        chk("R4", "jan 1", {r_mday, r_mon, r_year}, 24'h010100);

        // R4 leap rules
        load(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
        do_tick(hi);
        chk("R4", "leap feb 29", {r_mday, r_mon}, 16'h2902);
        do_tick(hi);
        load(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23);
        do_tick(hi);
        chk("R4", "non-leap mar 1", {r_mday, r_mon}, 16'h0103);
        load(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h00);
        do_tick(hi);
        chk("R4", "century leap feb 29", {r_mday, r_mon}, 16'h2902);
        load(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h10);
        do_tick(hi);
        chk("R4", "apr 30 -> may 1", {r_mday, r_mon}, 16'h0105);

        // R5 binary mode
        bin_mode = 1'b1;
        load(8'd45, 8'd30, 8'd17, 8'd2, 8'd19, 8'd11, 8'd42);
        do_tick(hi);
        chk("R5", "binary sec", r_sec, 8'd46);
        chk("R5", "binary hour/mday", {r_hour, r_mday}, {8'd17, 8'd19});
        bin_mode = 1'b0;

        // R6 / R7 12-hour
        h24_mode = 1'b0;
        load(8'h59, 8'h59, 8'h11, 8'h02, 8'h10, 8'h05, 8'h30);
        do_tick(hi);
        chk("R6", "11AM -> 12PM", r_hour, 8'h92);
        load(8'h59, 8'h59, 8'h92, 8'h02, 8'h10, 8'h05, 8'h30);
        do_tick(hi);
        chk("R7", "12PM -> 1PM", r_hour, 8'h81);
        load(8'h59, 8'h59, 8'h91, 8'h07, 8'h10, 8'h05, 8'h30);
        do_tick(hi);
        chk("R6", "11PM -> 12AM", r_hour, 8'h12);
        chk("R4", "12h midnight wday", r_wday, 8'h01);
        load(8'h59, 8'h59, 8'h12, 8'h02, 8'h10, 8'h05, 8'h30);
        do_tick(hi);
        chk("R7", "12AM -> 1AM", r_hour, 8'h01);

        // R8 alarm with 12-hour decode of the alarm hour
        load(8'h00, 8'h00, 8'h81, 8'h02, 8'h10, 8'h05, 8'h30);
        ack();
        alm_sec = 8'h01; alm_min = 8'hC0; alm_hour = 8'h81;
        do_tick(hi);
        chk("R8", "12h alarm hit", alarm_flag, 1);
        chk("R9", "no irq with enables off", irq, 0);
        h24_mode = 1'b1;

        // R8 exact and mismatching alarm
        load(8'h30, 8'h20, 8'h10, 8'h02, 8'h10, 8'h05, 8'h30);
        ack();
        alm_sec = 8'h32; alm_min = 8'h20; alm_hour = 8'h10;
        do_tick(hi);
        chk("R8", "alarm miss", alarm_flag, 0);
        alm_sec = 8'h32;
        do_tick(hi);
        chk("R8", "alarm exact hit", alarm_flag, 1);

        // R9 interrupt enables
        ack();
        alm_irq_en = 1'b1;
        alm_sec = 8'hC0; alm_min = 8'hC0; alm_hour = 8'hC0;
        do_tick(hi);
        chk("R9", "alarm irq", {alarm_flag, irq}, 2'b11);
        ack();
        chk("R10", "ack clears", {alarm_flag, upd_flag, irq}, 3'b000);
        alm_irq_en = 1'b0; alm_sec = 8'h77;
        upd_irq_en = 1'b1;
        do_tick(hi);
        chk("R9", "update irq", {upd_flag, irq}, 2'b11);

        // R10 ack in the same cycle as the finish phase
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        repeat (UIPC) @(negedge clk);
        flag_ack = 1'b1;
        @(negedge clk); flag_ack = 1'b0;
        chk("R10", "new flag survives ack", {upd_flag, irq}, 2'b11);
        upd_irq_en = 1'b0;
        ack();

        // R2 divider not running
        load(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        div_sel = 3'b000;
        do_tick(hi);
        chk("R2", "stopped: no uip", hi, 0);
        chk("R2", "stopped: sec held", r_sec, 8'h10);
        chk("R2", "stopped: no upd_flag", upd_flag, 0);
        div_sel = 3'b010;

        // R3 set mode
        set_mode = 1'b1;
        do_tick(hi);
        chk("R3", "set: no uip", hi, 0);
        chk("R3", "set: display frozen", r_sec, 8'h10);
        chk("R3", "set: upd_flag", upd_flag, 1);
        set_mode = 1'b0;
        do_tick(hi);
        chk("R3", "time kept counting under set", r_sec, 8'h12);

        // R7 load collides with tick
        @(negedge clk);
        ld_sec = 8'h33; ld_min = 8'h44; ld_hour = 8'h05; ld_wday = 8'h03;
        ld_mday = 8'h07; ld_mon = 8'h08; ld_year = 8'h09;
        load_stb = 1'b1; sec_tick = 1'b1;
        @(negedge clk);
        load_stb = 1'b0; sec_tick = 1'b0;
        hi = 0;
        repeat (UIPC + 4) begin
            if (uip) hi++;
            @(negedge clk);
        end
        chk("R7", "tick dropped on load", hi, 0);
        chk("R7", "loaded bytes shown", {r_sec, r_min, r_hour}, 24'h334405);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule